// File: doc/BRIEF.md
# GPIO Port with Single-Pin Event Interrupt

A 16-pin general-purpose I/O block on a simple 16-bit word-addressed register bus. Software programs each pin as input or output, drives output pins from an output latch and reads every pin level through a synchronized input register. A control register carries a clock-enable bit. When that bit is clear, the input synchronizers, the input register and edge detection all hold their state.

An event-mode register chooses one pin and one edge polarity. A matching edge on that pin sets a GPIO status bit. The same status register also holds a keypad request bit, which follows an external keypad request input. A mask register gates both bits onto one shared interrupt line. Reading the status register clears the GPIO bit and leaves the keypad bit alone. An edge that lands in the same cycle as that read keeps the GPIO bit set.

Bus reads are combinational from `bus_addr_i` while `bus_sel_i` is high and `bus_we_i` is low. Writes, and the clear caused by a read, take effect on the rising clock edge.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset, the direction register reads 0xFFFF (`pad_oe_o` = 0). The output latch, control register and event-mode register read 0. The mask register reads 0x0003, and `irq_o` is low.
- R2: The direction register at offset 2 holds one bit per pin. A 1 makes the pin an input and a 0 makes it an output, so `pad_oe_o` is the inverse of the register. It reads back as written.
- R3: The output latch at offset 1 drives `pad_out_o` from the clock edge that writes it, and it reads back as written.
- R4: The input register at offset 0 returns `pad_in_i` through a two-flop synchronizer, so a pin change is visible after two rising clock edges.
- R5: Bit 5 of the control register at offset 3 is the clock enable. While it is 0, the input register holds its value and no GPIO event is detected.
- R6: The event-mode register is at offset 4. Bit 0 enables event mode, bits 4:1 give the monitored pin index, and bit 5 gives the polarity (1 = rising, 0 = falling). A matching edge on the synchronized pin sets status bit 1 on the third rising clock edge after the pin changes. An edge of the other polarity, or any edge while bit 0 is 0, has no effect.
- R7: The interrupt status register is at offset 5. Bit 0 follows the level of `kpd_req_i` and bit 1 is the GPIO event. A read returns the current value and then clears bit 1 only.
- R8: The interrupt mask register at offset 6 has bit 0 for the keypad and bit 1 for GPIO, where 1 masks the source. `irq_o` is high while any unmasked status bit is set.
- R9: A GPIO event that arrives on the same clock edge as a status read leaves status bit 1 set.
- R10: Writes to offsets 0 and 5 are ignored, and offset 7 reads as 0.
- R11: Changing the monitored pin index does not, by itself, raise a GPIO event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| pad_in_i | input | 16 | Pin levels |
| pad_out_o | output | 16 | Output latch value |
| pad_oe_o | output | 16 | Output enable per pin |
| kpd_req_i | input | 1 | Keypad interrupt request level |
| irq_o | output | 1 | Shared interrupt |

## Verification
The bench targets four corner cases:

- **Read coinciding with an edge.** The bench times a status read so that its clock edge coincides with a rising edge on the monitored pin. A design that lets the clear win would lose that event.
- **Switching the monitored pin.** The bench changes the pin index from a low pin to a high pin. A design that remembers only the previous level of the selected pin would report a false edge.
- **Keypad bit and polarity.** The bench reads the status register twice with the keypad request held high, to catch a clear that also hits the keypad bit. It also drives edges of the wrong polarity, which must not set the GPIO bit.
- **Clock enable off.** The bench changes the pins while the clock enable is clear. A design that keeps sampling would show the new level or raise an event.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned NPIN = 16;
  localparam int unsigned DW   = 16;
  localparam int unsigned AW   = 3;
  localparam int unsigned SELW = $clog2(NPIN);
  localparam int unsigned CLK_EN_BIT = 5;

  typedef enum logic [AW-1:0] {
    A_IN   = 3'd0,
    A_OUT  = 3'd1,
    A_DIR  = 3'd2,
    A_CTRL = 3'd3,
    A_EVT  = 3'd4,
    A_ST   = 3'd5,
    A_MSK  = 3'd6
  } reg_addr_e;

  // event-mode layout: {pol, pin, en}
  typedef struct packed {
    logic            pol;
    logic [SELW-1:0] pin;
    logic            en;
  } evt_cfg_t;

  localparam int unsigned EVTW = $bits(evt_cfg_t);
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   stg_q[s] <= '0;
      else if (en_i) stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  // R5
  hold_when_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_evt_pkg::*;
#(
  parameter int unsigned W = NPIN
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clk_en_i,
  input  evt_cfg_t cfg_i,
  input  logic [W-1:0] sync_i,
  output logic     evt_o
);
  // full previous vector so a change of pin index cannot fake an edge
  logic [W-1:0] prev_q;
  logic cur, prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= '0;
    else if (clk_en_i) prev_q <= sync_i;
  end

  assign cur   = sync_i[cfg_i.pin];
  assign prv   = prev_q[cfg_i.pin];
  assign evt_o = clk_en_i && cfg_i.en && (cfg_i.pol ? (cur && !prv) : (!cur && prv));

  // R6
  evt_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> ($past(sync_i[cfg_i.pin]) != $past(prev_q[cfg_i.pin])) || !$stable(cfg_i.pin));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kpd_i,
  input  logic       evt_i,
  input  logic       rd_clr_i,
  input  logic [1:0] msk_i,
  output logic [1:0] st_o,
  output logic       irq_o
);
  logic gpio_st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gpio_st_q <= 1'b0;
    else if (evt_i)    gpio_st_q <= 1'b1;  // new event beats the clear
    else if (rd_clr_i) gpio_st_q <= 1'b0;
  end

  assign st_o  = {gpio_st_q, kpd_i};
  assign irq_o = |(st_o & ~msk_i);

  // R9
  evt_sets_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> st_o[1]);
  // R7
  rd_clears_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !evt_i) |=> !st_o[1]);
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
  import gpio_evt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [NPIN-1:0] pad_in_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o,
  input  logic          kpd_req_i,
  output logic          irq_o
);
  logic [NPIN-1:0] out_q, dir_q, in_sync;
  logic            clk_en_q;
  evt_cfg_t        evt_q;
  logic [1:0]      msk_q, st;
  logic            wr, rd, evt;

  assign wr = bus_sel_i &&  bus_we_i;
  assign rd = bus_sel_i && !bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      dir_q    <= '1;
      clk_en_q <= 1'b0;
      evt_q    <= '0;
      msk_q    <= 2'b11;
    end else if (wr) begin
      unique case (bus_addr_i)
        A_OUT:   out_q    <= bus_wdata_i[NPIN-1:0];
        A_DIR:   dir_q    <= bus_wdata_i[NPIN-1:0];
        A_CTRL:  clk_en_q <= bus_wdata_i[CLK_EN_BIT];
        A_EVT:   evt_q    <= evt_cfg_t'(bus_wdata_i[EVTW-1:0]);
        A_MSK:   msk_q    <= bus_wdata_i[1:0];
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .en_i(clk_en_q), .d_i(pad_in_i), .q_o(in_sync)
  );

  gpio_edge_det #(.W(NPIN)) u_edge (
    .clk_i, .rst_ni, .clk_en_i(clk_en_q), .cfg_i(evt_q), .sync_i(in_sync), .evt_o(evt)
  );

  gpio_irq_ctrl u_irq (
    .clk_i, .rst_ni, .kpd_i(kpd_req_i), .evt_i(evt),
    .rd_clr_i(rd && bus_addr_i == A_ST), .msk_i(msk_q), .st_o(st), .irq_o
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (bus_addr_i)
        A_IN:    bus_rdata_o[NPIN-1:0] = in_sync;
        A_OUT:   bus_rdata_o[NPIN-1:0] = out_q;
        A_DIR:   bus_rdata_o[NPIN-1:0] = dir_q;
        A_CTRL:  bus_rdata_o[CLK_EN_BIT] = clk_en_q;
        A_EVT:   bus_rdata_o[EVTW-1:0] = evt_q;
        A_ST:    bus_rdata_o[1:0] = st;
        A_MSK:   bus_rdata_o[1:0] = msk_q;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign pad_out_o = out_q;
  assign pad_oe_o  = ~dir_q;

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_DIR) |=> pad_oe_o == ~$past(bus_wdata_i[NPIN-1:0]));
  // R3
  out_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_OUT) |=> pad_out_o == $past(bus_wdata_i[NPIN-1:0]));
  // R10
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (bus_addr_i == A_IN || bus_addr_i == A_ST)) |=> $stable(pad_out_o) && $stable(pad_oe_o));
endmodule

// File: tb/gpio_evt_port_bench.sv
module gpio_evt_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic kpd = 1'b0, irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_port u_gpio_evt_port (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .kpd_req_i(kpd), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 sel = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 sel = 0;
  endtask

  task automatic set_pad(input logic [15:0] v);
    @(negedge clk); pad_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 oe", pad_oe, 16'h0000);
    chk("R1 out", pad_out, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rd(3'd2, d); chk("R1 dir", d, 16'hFFFF);
    rd(3'd6, d); chk("R1 mask", d, 16'h0003);
    rd(3'd3, d); chk("R1 ctrl", d, 16'h0000);
    rd(3'd4, d); chk("R1 evt", d, 16'h0000);
  endtask

  task automatic t_dir_out();
    logic [15:0] d;
    wr(3'd1, 16'hA5C3); chk("R3 pad_out", pad_out, 16'hA5C3);
    rd(3'd1, d); chk("R3 readback", d, 16'hA5C3);
    wr(3'd2, 16'h00F0); chk("R2 pad_oe", pad_oe, 16'hFF0F);
    rd(3'd2, d); chk("R2 readback", d, 16'h00F0);
  endtask

  task automatic t_input();
    logic [15:0] d;
    wr(3'd3, 16'h0020);
    @(negedge clk); pad_in = 16'h1234;
    @(posedge clk); @(negedge clk); sel = 1; addr = 3'd0; #1 d = rdata; sel = 0;
    chk("R4 one edge not yet", d, 16'h0000);
    @(posedge clk); @(negedge clk); sel = 1; addr = 3'd0; #1 d = rdata; sel = 0;
    chk("R4 two edges", d, 16'h1234);
  endtask

  task automatic t_ro();
    logic [15:0] d;
    wr(3'd0, 16'hFFFF); rd(3'd0, d); chk("R10 input ro", d, 16'h1234);
    wr(3'd5, 16'h0003); rd(3'd5, d); chk("R10 status ro", d, 16'h0000);
    rd(3'd7, d); chk("R10 hole", d, 16'h0000);
  endtask

  task automatic t_rising();
    logic [15:0] d;
    wr(3'd6, 16'h0000);
    wr(3'd4, 16'h0027); // en, pin 3, rising
    set_pad(16'h123C); chk("R6 rising irq", {15'd0, irq}, 16'h0001);
    rd(3'd5, d); chk("R7 read shows gpio", d, 16'h0002);
    chk("R7 irq after clear", {15'd0, irq}, 16'h0000);
    rd(3'd5, d); chk("R7 cleared", d, 16'h0000);
    set_pad(16'h1234); chk("R6 falling ignored", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_falling();
    logic [15:0] d;
    wr(3'd4, 16'h0007); // en, pin 3, falling
    set_pad(16'h123C); chk("R6 rising ignored", {15'd0, irq}, 16'h0000);
    set_pad(16'h1234); chk("R6 falling irq", {15'd0, irq}, 16'h0001);
    rd(3'd5, d); chk("R6 falling status", d, 16'h0002);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    wr(3'd4, 16'h0006); // pin 3 falling, event mode off
    set_pad(16'h123C); set_pad(16'h1234);
    rd(3'd5, d); chk("R6 mode off", d, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(3'd6, 16'h0002);
    wr(3'd4, 16'h0027);
    set_pad(16'h123C); chk("R8 gpio masked", {15'd0, irq}, 16'h0000);
    rd(3'd5, d); chk("R8 status still set", d, 16'h0002);
  endtask

  task automatic t_keypad();
    logic [15:0] d;
    wr(3'd6, 16'h0003);
    @(negedge clk); kpd = 1;
    #1 chk("R8 kpd masked", {15'd0, irq}, 16'h0000);
    rd(3'd5, d); chk("R7 kpd level", d, 16'h0001);
    rd(3'd5, d); chk("R7 kpd not cleared", d, 16'h0001);
    wr(3'd6, 16'h0000); chk("R8 kpd unmasked", {15'd0, irq}, 16'h0001);
    @(negedge clk); kpd = 0;
    #1 chk("R8 kpd drop", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_sel_switch();
    logic [15:0] d;
    // pad 0x123C: pin 0 low, pin 5 high
    wr(3'd4, 16'h0021);
    repeat (3) @(posedge clk);
    rd(3'd5, d);
    wr(3'd4, 16'h002B); // pin 5 rising
    repeat (3) @(posedge clk);
    rd(3'd5, d); chk("R11 no spurious", d, 16'h0000);
  endtask

  task automatic t_clk_en();
    logic [15:0] d;
    wr(3'd4, 16'h0027);
    wr(3'd3, 16'h0000);
    set_pad(16'h1234); set_pad(16'h123C);
    rd(3'd0, d); chk("R5 input held", d, 16'h123C);
    set_pad(16'h1234); set_pad(16'h123C);
    set_pad(16'h5678);
    rd(3'd0, d); chk("R5 input frozen", d, 16'h123C);
    rd(3'd5, d); chk("R5 no event", d, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd3, 16'h0020);
    repeat (3) @(posedge clk);
    rd(3'd0, d); chk("R5 resumes", d, 16'h5678);
    rd(3'd5, d);
  endtask

  task automatic t_race();
    logic [15:0] d;
    set_pad(16'h0000);
    wr(3'd4, 16'h0027);
    repeat (2) @(posedge clk);
    rd(3'd5, d);
    @(negedge clk); pad_in = 16'h0008;
    @(posedge clk); @(posedge clk);
    @(negedge clk); sel = 1; we = 0; addr = 3'd5;
    #1 d = rdata;
    @(posedge clk); #1 sel = 0;
    chk("R9 before event", d, 16'h0000);
    rd(3'd5, d); chk("R9 event survives read", d, 16'h0002);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_dir_out();
    t_input();
    t_ro();
    t_rising();
    t_falling();
    t_disabled();
    t_mask();
    t_keypad();
    t_sel_switch();
    t_clk_en();
    t_race();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule